// File: doc/BRIEF.md
# Two-Half Receive Word Reader

This block sits between a serial word receiver and a 16-bit host bus. Each time the receiver hands over a finished 32-bit word, the block stores it and raises a ready flag. The host then fetches the word in two read cycles. The first read returns the low half and the second read returns the high half.

Reads use an active-low strobe that lasts one clock. While the strobe is low, the selected half appears combinationally on the data output. An internal half pointer picks which half is returned. Every new word overwrites the stored word and sends the pointer back to the low half. This happens even if only the low half of the previous word has been read. There is no overrun protection: an unread word is simply replaced.

Top module: `word_half_reader`

## Requirements
- R1: After a synchronous active-low reset, `data_ready` is 0, the stored word is all zeros, and the pointer selects the low half, so a first read returns 16'h0000.
- R2: A cycle with `load` high makes `data_ready` 1 in the next cycle.
- R3: A read with the pointer on the low half presents word bits [15:0] on `rd_data[15:0]`. A read with the pointer on the high half presents word bits [31:16]. Each read then moves the pointer to the other half.
- R4: A read of the low half with no `load` in the same cycle clears `data_ready` in the next cycle.
- R5: A read of the high half leaves `data_ready` unchanged and wraps the pointer to the low half. A third read with no new word returns the low half again.
- R6: `load` always replaces the stored word, whether or not the previous word was read, and the previous contents are no longer returned.
- R7: `load` between the two reads of a pair resets the pointer, so the next read returns bits [15:0] of the new word.
- R8: When `load` and a read strobe fall in the same cycle, the read returns the old word's selected half during that cycle. The load then wins: in the next cycle `data_ready` is 1 and the pointer is on the low half.
- R9: While `rd_n` is high, `rd_data` is 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | One-cycle strobe: a new word is being transferred in |
| load_word | input | 32 | Received word; bit 0 is the first received bit |
| rd_n | input | 1 | Active-low single-cycle read strobe |
| rd_data | output | 16 | Selected half while `rd_n` is low, zero otherwise |
| data_ready | output | 1 | High from a new word until its low half is read |

## Verification
A pointer left on the wrong half shows up on the very next read strobe: that read returns the other half of the word. This is most visible right after a load that lands between two reads, and in a load that collides with a read. A stuck or wrongly cleared ready flag differs from the expected value one cycle after the load or the low-half read. A random mix of loads and reads is compared each cycle against a bench model, so such a fault is seen within a few cycles.

// File: rtl/whr_pkg.sv
// Package: shared types for the two-half word reader.
// Assumes a word is split into exactly two equal halves.
package whr_pkg;
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;
endpackage

// File: rtl/whr_word_store.sv
// Word store: holds the most recently loaded word.
// Assumes load is a one-cycle strobe; each load overwrites the word unconditionally.
module whr_word_store #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    output logic [WORD_W-1:0] word_q
);
    // Capture the incoming word on every load; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= load_word;
        end
    end
endmodule

// File: rtl/whr_seq_ctrl.sv
// Sequence control: half pointer and ready flag.
// A load has priority over a read in the same cycle. A low-half read clears the
// flag, and every read toggles the pointer.
module whr_seq_ctrl
    import whr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  logic  rd_n,
    output half_e ptr_q,
    output logic  ready_q
);
    logic rd_act;
    assign rd_act = !rd_n;

    // Advance the pointer on reads; force it to the low half on load or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= HALF_LO;
        end else if (load) begin
            ptr_q <= HALF_LO;
        end else if (rd_act) begin
            ptr_q <= (ptr_q == HALF_LO) ? HALF_HI : HALF_LO;
        end
    end

    // Raise the ready flag on load; drop it when the low half is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else if (load) begin
            ready_q <= 1'b1;
        end else if (rd_act && ptr_q == HALF_LO) begin
            ready_q <= 1'b0;
        end
    end
endmodule

// File: rtl/whr_half_mux.sv
// Half multiplexer: slices the stored word into halves and drives the selected
// half while the read strobe is low. Assumes WORD_W == 2*HALF_W.
module whr_half_mux
    import whr_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int NHALF  = 2
) (
    input  logic [NHALF*HALF_W-1:0] word_q,
    input  half_e                   sel,
    input  logic                    rd_n,
    output logic [HALF_W-1:0]       rd_data
);
    logic [HALF_W-1:0] halves [NHALF];

    for (genvar g = 0; g < NHALF; g++) begin : g_slice
        assign halves[g] = word_q[g*HALF_W +: HALF_W];
    end

    // Present the selected half during a read, zeros otherwise.
    always_comb begin
        if (rd_n) begin
            rd_data = '0;
        end else begin
            rd_data = halves[int'(sel)];
        end
    end
endmodule

// File: rtl/word_half_reader.sv
// Top: two-half receive word reader. Stores the latest word and hands it to a
// host in two reads. Assumes load and rd_n are synchronous to clk.
module word_half_reader
    import whr_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              rd_n,
    output logic [HALF_W-1:0] rd_data,
    output logic              data_ready
);
    logic [WORD_W-1:0] word_q;
    half_e             ptr_q;
    logic              half_sel;

    whr_word_store #(.WORD_W(WORD_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (load_word),
        .word_q    (word_q)
    );

    whr_seq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .rd_n    (rd_n),
        .ptr_q   (ptr_q),
        .ready_q (data_ready)
    );

    whr_half_mux #(.HALF_W(HALF_W), .NHALF(2)) u_mux (
        .word_q  (word_q),
        .sel     (ptr_q),
        .rd_n    (rd_n),
        .rd_data (rd_data)
    );

    assign half_sel = (ptr_q == HALF_HI);
endmodule

// File: rtl/whr_checker.sv
// Checker: temporal properties of the two-half word reader, bound to the top.
module whr_checker #(
    parameter int HALF_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                load,
    input logic [2*HALF_W-1:0] load_word,
    input logic                rd_n,
    input logic [HALF_W-1:0]   rd_data,
    input logic                data_ready,
    input logic                half_sel
);
    assert_ready_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> data_ready);

    assert_low_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !load && !half_sel) |=> (!data_ready && half_sel));

    assert_high_read_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !load && half_sel) |=> ($stable(data_ready) && !half_sel));

    assert_load_resets_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !half_sel);

    assert_new_low_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (rd_n || rd_data == $past(load_word[HALF_W-1:0])));

    assert_collision_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !rd_n) |=> (data_ready && !half_sel));

    assert_idle_bus_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> (rd_data == '0));
endmodule

bind word_half_reader whr_checker #(.HALF_W(HALF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_word  (load_word),
    .rd_n       (rd_n),
    .rd_data    (rd_data),
    .data_ready (data_ready),
    .half_sel   (half_sel)
);

// File: tb/word_half_reader_tb.sv
module word_half_reader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [31:0] load_word = '0;
    logic        rd_n = 1'b1;
    logic [15:0] rd_data;
    logic        data_ready;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state
    logic [31:0] m_word = '0;
    bit          m_ptr = 1'b0;
    bit          m_rdy = 1'b0;

    always #2 clk = ~clk;

    word_half_reader u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_word  (load_word),
        .rd_n       (rd_n),
        .rd_data    (rd_data),
        .data_ready (data_ready)
    );

    function automatic logic [15:0] exp_half(logic [31:0] w, bit p, bit rdn);
        if (rdn) return 16'h0000;
        return p ? w[31:16] : w[15:0];
    endfunction

    task automatic check16(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s rd_data actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check1(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s data_ready actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One cycle: check flag, drive inputs, check bus, advance model.
    task automatic step(bit ld, logic [31:0] w, bit rdn, string req);
        @(negedge clk);
        check1(req, data_ready, m_rdy);
        load = ld;
        load_word = w;
        rd_n = rdn;
        #1;
        check16(req, rd_data, exp_half(m_word, m_ptr, rdn));
        if (ld) begin
            m_word = w;
            m_ptr = 1'b0;
            m_rdy = 1'b1;
        end else if (!rdn) begin
            if (!m_ptr) m_rdy = 1'b0;
            m_ptr = ~m_ptr;
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, and a read returns zeros from the cleared word
        step(0, '0, 1, "R1");
        step(0, '0, 0, "R1");
        step(0, '0, 1, "R9");
        step(0, '0, 0, "R5");   // high half of the zero word; pointer wraps
        // R2/R3/R4: load then a full read pair
        step(1, 32'hA5C3_1E2D, 1, "R2");
        step(0, '0, 1, "R2");
        step(0, '0, 0, "R3");
        step(0, '0, 0, "R4");
        step(0, '0, 0, "R5");   // third read returns low half again
        step(0, '0, 1, "R5");
        // R6: unread word overwritten
        step(1, 32'h1111_2222, 1, "R6");
        step(1, 32'h3333_4444, 1, "R6");
        step(0, '0, 0, "R6");
        step(0, '0, 0, "R6");
        // R7: load between halves
        step(1, 32'hDEAD_BEEF, 1, "R7");
        step(0, '0, 0, "R7");
        step(1, 32'hCAFE_F00D, 1, "R7");
        step(0, '0, 0, "R7");
        step(0, '0, 0, "R7");
        // R8: load and read collide, both on the low and the high half
        step(1, 32'h0F0F_F0F0, 1, "R8");
        step(1, 32'h1234_5678, 0, "R8");
        step(0, '0, 0, "R8");
        step(1, 32'h9ABC_DEF0, 0, "R8");
        step(0, '0, 1, "R8");
        step(0, '0, 0, "R8");
        // Random mix
        for (int i = 0; i < 400; i++) begin
            bit ld  = ($urandom % 4) == 0;
            bit rdn = ($urandom % 2) == 0;
            step(ld, $urandom, rdn, "R3");
        end
        step(0, '0, 1, "R9");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule